// File: doc/BRIEF.md
# Display Output Channel Controller

This block is the control and status logic of a single compositor output channel. Software programs a control word with an enable, a self-clearing reset, a one-shot selector and the active frame width and height. The block then walks the channel through its modes. An enabled channel first waits for a vertical-start pulse, then runs a frame of `height` lines, and afterwards either waits for the next vertical start or, in one-shot mode, parks in a done mode.

Next to the mode sequencer, the block tracks the fill level of the channel's output FIFO from push and pixel-request strobes, and it reports full and empty. It latches an underrun when the downstream side asks for a pixel from an empty FIFO while a frame is running. It also latches an end-of-frame event. Each of the two latched flags is cleared by writing 1 to it, and each has its own interrupt enable. The pixel datapath lies outside this block. It receives the width and height through the `cfg_*` outputs and the running state through `running`.

Top module: `dchan_ctrl`

## Requirements
- R1: Writing enable=1 (control word, address 0, bit 0) does not start output. The mode (status address 1, bits [1:0]: 0 off, 1 waiting, 2 running, 3 one-shot done) becomes 1 one cycle after the write. It stays 1, whatever arrives on `line_end`, until a `vstart` pulse moves it to 2.
- R2: While running, a frame ends on the `line_end` pulse that completes `height` lines (a height of 0 counts as 1). With one-shot clear, the mode then returns to 1, and the next `vstart` starts a new frame. Frame end sets the end-of-frame flag (status bit 5).
- R3: With one-shot set (control bit 2), the mode goes to 3 after one frame. It stays there, ignoring `vstart`, until enable is cleared.
- R4: The control word reads back with width in bits [15:4], height in bits [27:16], one-shot in bit 2 and enable in bit 0. The width and height also drive `cfg_width` and `cfg_height`.
- R5: When enable is cleared during a running frame, the mode stays 2 until the next `line_end`, then becomes 0. When it is cleared in mode 1 or 3, the mode becomes 0 one cycle later.
- R6: Control bit 1 is a reset that always reads back 0. A write with it set clears enable, and after that write the mode is 0, the FIFO is empty and not full.
- R7: Status bit 2 (`fifo_full`) is set exactly when the level equals `FIFO_DEPTH`, and status bit 3 (`fifo_empty`) exactly when the level is 0. A push at full and a request at empty leave the level unchanged.
- R8: A `pix_req` while the FIFO is empty and the mode is 2 sets the underrun flag (status bit 4). The same strobe in any other mode does not set it.
- R9: Writing 1 to status bit 4 or bit 5 clears that flag. Writing 0 leaves it unchanged.
- R10: `irq` is high when some flag is set and its enable (address 2: bit 0 underrun, bit 1 end-of-frame) is set. A flag whose enable is clear does not raise `irq`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | 2 | Register write address |
| wr_data | input | 32 | Register write data |
| rd_addr | input | 2 | Register read address |
| rd_data | output | 32 | Register read data (combinational) |
| vstart | input | 1 | Vertical-start pulse |
| line_end | input | 1 | End-of-line pulse from the output timing |
| fifo_push | input | 1 | One pixel written into the output FIFO |
| pix_req | input | 1 | Downstream pixel request (pops one pixel) |
| fifo_full | output | 1 | FIFO at full depth |
| fifo_empty | output | 1 | FIFO holds no pixel |
| running | output | 1 | Channel is in the running mode |
| cfg_width | output | 12 | Programmed active width |
| cfg_height | output | 12 | Programmed active height |
| irq | output | 1 | Interrupt request |

## Verification
A line counter that is off by one moves the done or waiting mode one `line_end` early or late, and the status read right after that pulse shows it. A mode register that leaves running on its own shows up at once as an unexpected mode or a missing underrun. A level counter that drifts changes `fifo_full` or `fifo_empty` on the first push or request past the true boundary. A flag that clears wrongly or sets spuriously shows in status bits 4 and 5 and on `irq` in the cycle after the offending strobe or write.

// File: rtl/dchan_pkg.sv
package dchan_pkg;

    localparam int DIM_W = 12;
    localparam int REG_W = 32;

    localparam logic [1:0] A_CTRL  = 2'd0;
    localparam logic [1:0] A_STAT  = 2'd1;
    localparam logic [1:0] A_IRQEN = 2'd2;

    localparam int C_EN   = 0;
    localparam int C_RST  = 1;
    localparam int C_ONE  = 2;
    localparam int C_WLSB = 4;
    localparam int C_HLSB = C_WLSB + DIM_W;

    localparam int S_UFL = 4;
    localparam int S_EOF = 5;

    typedef enum logic [1:0] {
        MODE_OFF  = 2'd0,
        MODE_WAIT = 2'd1,
        MODE_RUN  = 2'd2,
        MODE_DONE = 2'd3
    } mode_e;

    typedef struct packed {
        logic [DIM_W-1:0] height;
        logic [DIM_W-1:0] width;
        logic             oneshot;
        logic             enable;
    } ctrl_t;

    function automatic ctrl_t ctrl_decode(input logic [REG_W-1:0] w);
        ctrl_t c;
        c.height  = w[C_HLSB +: DIM_W];
        c.width   = w[C_WLSB +: DIM_W];
        c.oneshot = w[C_ONE];
        c.enable  = w[C_EN] & ~w[C_RST];
        return c;
    endfunction

    function automatic logic [REG_W-1:0] ctrl_encode(input ctrl_t c);
        logic [REG_W-1:0] w;
        w = '0;
        w[C_HLSB +: DIM_W] = c.height;
        w[C_WLSB +: DIM_W] = c.width;
        w[C_ONE] = c.oneshot;
        w[C_EN]  = c.enable;
        return w;
    endfunction

endpackage

// File: rtl/dchan_regs.sv
module dchan_regs
    import dchan_pkg::*;
(
    input  logic             clk,
    input  logic             rst,
    input  logic             wr_en,
    input  logic [1:0]       wr_addr,
    input  logic [REG_W-1:0] wr_data,
    input  logic [1:0]       rd_addr,
    output logic [REG_W-1:0] rd_data,
    input  logic             ufl_evt,
    input  logic             eof_evt,
    input  mode_e            mode,
    input  logic             full,
    input  logic             empty,
    output ctrl_t            ctrl_o,
    output logic             flush_o,
    output logic             irq_o
);

    ctrl_t      ctrl_q;
    logic [1:0] ien_q;
    logic       ufl_q, eof_q;
    logic       wr_ctrl, wr_stat, wr_ien;
    logic       unused_bits;

    assign wr_ctrl = wr_en && (wr_addr == A_CTRL);
    assign wr_stat = wr_en && (wr_addr == A_STAT);
    assign wr_ien  = wr_en && (wr_addr == A_IRQEN);
    assign flush_o = wr_ctrl && wr_data[C_RST];
    assign unused_bits = ^{wr_data[REG_W-1:C_HLSB+DIM_W], wr_data[3]};

    always_ff @(posedge clk) begin
        if (rst) begin
            ctrl_q <= '0;
            ien_q  <= '0;
            ufl_q  <= 1'b0;
            eof_q  <= 1'b0;
        end else begin
            if (wr_ctrl) ctrl_q <= ctrl_decode(wr_data);
            if (wr_ien)  ien_q  <= wr_data[1:0];
            ufl_q <= ufl_evt | (ufl_q & ~(wr_stat & wr_data[S_UFL]));
            eof_q <= eof_evt | (eof_q & ~(wr_stat & wr_data[S_EOF]));
        end
    end

    assign ctrl_o = ctrl_q;
    assign irq_o  = |({eof_q, ufl_q} & ien_q);

    always_comb begin
        rd_data = '0;
        case (rd_addr)
            A_CTRL:  rd_data = ctrl_encode(ctrl_q);
            A_STAT:  rd_data = {{(REG_W-6){1'b0}}, eof_q, ufl_q, empty, full, mode};
            A_IRQEN: rd_data = {{(REG_W-2){1'b0}}, ien_q};
            default: rd_data = '0;
        endcase
    end

    AST_UFL_NEEDS_EVENT: assert property (@(posedge clk) disable iff (rst)
        $rose(ufl_q) |-> $past(ufl_evt)); // R8
    AST_W1C_CLEARS: assert property (@(posedge clk) disable iff (rst)
        (wr_stat && wr_data[S_UFL] && !ufl_evt) |=> !ufl_q); // R9
    AST_IRQ_ON_UFL: assert property (@(posedge clk) disable iff (rst)
        (ufl_evt && ien_q[0] && !wr_ien) |=> irq_o); // R10

endmodule

// File: rtl/dchan_fsm.sv
module dchan_fsm
    import dchan_pkg::*;
(
    input  logic             clk,
    input  logic             rst,
    input  logic             enable_i,
    input  logic             oneshot_i,
    input  logic [DIM_W-1:0] height_i,
    input  logic             vstart_i,
    input  logic             line_end_i,
    input  logic             flush_i,
    output mode_e            mode_o,
    output logic             frame_done_o
);

    mode_e            mode_q, mode_d;
    logic [DIM_W-1:0] line_q;
    logic [DIM_W:0]   line_nxt;
    logic             last;

    assign line_nxt = {1'b0, line_q} + 1'b1;
    assign last     = line_nxt >= {1'b0, height_i};

    always_comb begin
        mode_d = mode_q;
        case (mode_q)
            MODE_OFF:  if (enable_i) mode_d = MODE_WAIT;
            MODE_WAIT: begin
                if (!enable_i)     mode_d = MODE_OFF;
                else if (vstart_i) mode_d = MODE_RUN;
            end
            MODE_RUN: begin
                if (line_end_i) begin
                    if (!enable_i) mode_d = MODE_OFF;
                    else if (last) mode_d = oneshot_i ? MODE_DONE : MODE_WAIT;
                end
            end
            MODE_DONE: if (!enable_i) mode_d = MODE_OFF;
            default:   mode_d = MODE_OFF;
        endcase
        if (flush_i) mode_d = MODE_OFF;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            mode_q <= MODE_OFF;
            line_q <= '0;
        end else begin
            mode_q <= mode_d;
            if (mode_q == MODE_WAIT && vstart_i)
                line_q <= '0;
            else if (mode_q == MODE_RUN && line_end_i)
                line_q <= last ? '0 : line_nxt[DIM_W-1:0];
        end
    end

    assign mode_o       = mode_q;
    assign frame_done_o = (mode_q == MODE_RUN) && line_end_i && last;

    AST_WAIT_NEEDS_VSTART: assert property (@(posedge clk) disable iff (rst)
        (mode_q == MODE_WAIT && !vstart_i) |=> (mode_q != MODE_RUN)); // R1
    AST_RUN_TO_LINE_END: assert property (@(posedge clk) disable iff (rst)
        (mode_q == MODE_RUN && !line_end_i && !flush_i) |=> (mode_q == MODE_RUN)); // R5
    AST_DONE_AFTER_LINE: assert property (@(posedge clk) disable iff (rst)
        $rose(mode_q == MODE_DONE) |-> $past(line_end_i)); // R3

endmodule

// File: rtl/dchan_level.sv
module dchan_level #(
    parameter int DEPTH = 8
) (
    input  logic clk,
    input  logic rst,
    input  logic flush_i,
    input  logic push_i,
    input  logic pop_i,
    output logic full_o,
    output logic empty_o
);

    localparam int CNT_W = $clog2(DEPTH + 1);
    localparam logic [CNT_W-1:0] LVL_MAX = CNT_W'(DEPTH);

    logic [CNT_W-1:0] lvl_q;
    logic             push_ok, pop_ok;

    assign full_o  = (lvl_q == LVL_MAX);
    assign empty_o = (lvl_q == '0);
    assign push_ok = push_i && !full_o;
    assign pop_ok  = pop_i && !empty_o;

    always_ff @(posedge clk) begin
        if (rst || flush_i)
            lvl_q <= '0;
        else if (push_ok && !pop_ok)
            lvl_q <= lvl_q + 1'b1;
        else if (pop_ok && !push_ok)
            lvl_q <= lvl_q - 1'b1;
    end

    AST_FLUSH_EMPTIES: assert property (@(posedge clk) disable iff (rst)
        flush_i |=> (empty_o && !full_o)); // R6
    AST_FULL_NEEDS_PUSH: assert property (@(posedge clk) disable iff (rst)
        $rose(full_o) |-> $past(push_i)); // R7

endmodule

// File: rtl/dchan_ctrl.sv
module dchan_ctrl
    import dchan_pkg::*;
#(
    parameter int FIFO_DEPTH = 8
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             wr_en,
    input  logic [1:0]       wr_addr,
    input  logic [REG_W-1:0] wr_data,
    input  logic [1:0]       rd_addr,
    output logic [REG_W-1:0] rd_data,
    input  logic             vstart,
    input  logic             line_end,
    input  logic             fifo_push,
    input  logic             pix_req,
    output logic             fifo_full,
    output logic             fifo_empty,
    output logic             running,
    output logic [DIM_W-1:0] cfg_width,
    output logic [DIM_W-1:0] cfg_height,
    output logic             irq
);

    ctrl_t ctrl;
    mode_e mode;
    logic  flush, frame_done, ufl_evt;

    assign ufl_evt = pix_req && fifo_empty && (mode == MODE_RUN);

    dchan_regs u_regs (
        .clk     (clk),
        .rst     (rst),
        .wr_en   (wr_en),
        .wr_addr (wr_addr),
        .wr_data (wr_data),
        .rd_addr (rd_addr),
        .rd_data (rd_data),
        .ufl_evt (ufl_evt),
        .eof_evt (frame_done),
        .mode    (mode),
        .full    (fifo_full),
        .empty   (fifo_empty),
        .ctrl_o  (ctrl),
        .flush_o (flush),
        .irq_o   (irq)
    );

    dchan_fsm u_fsm (
        .clk          (clk),
        .rst          (rst),
        .enable_i     (ctrl.enable),
        .oneshot_i    (ctrl.oneshot),
        .height_i     (ctrl.height),
        .vstart_i     (vstart),
        .line_end_i   (line_end),
        .flush_i      (flush),
        .mode_o       (mode),
        .frame_done_o (frame_done)
    );

    dchan_level #(.DEPTH(FIFO_DEPTH)) u_level (
        .clk     (clk),
        .rst     (rst),
        .flush_i (flush),
        .push_i  (fifo_push),
        .pop_i   (pix_req),
        .full_o  (fifo_full),
        .empty_o (fifo_empty)
    );

    assign running    = (mode == MODE_RUN);
    assign cfg_width  = ctrl.width;
    assign cfg_height = ctrl.height;

endmodule

// File: tb/test_dchan_ctrl.sv
`timescale 1ns/1ps
module test_dchan_ctrl;

    localparam int DEPTH = 8;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        wr_en = 1'b0;
    logic [1:0]  wr_addr = '0;
    logic [31:0] wr_data = '0;
    logic [1:0]  rd_addr = '0;
    logic [31:0] rd_data;
    logic        vstart = 1'b0, line_end = 1'b0, fifo_push = 1'b0, pix_req = 1'b0;
    logic        fifo_full, fifo_empty, running, irq;
    logic [11:0] cfg_width, cfg_height;

    int nchk = 0;
    int nfail = 0;
    bit finished = 0;

    always #10 clk = ~clk;

    dchan_ctrl #(.FIFO_DEPTH(DEPTH)) i_dchan_ctrl (
        .clk(clk), .rst(rst), .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
        .rd_addr(rd_addr), .rd_data(rd_data), .vstart(vstart), .line_end(line_end),
        .fifo_push(fifo_push), .pix_req(pix_req), .fifo_full(fifo_full),
        .fifo_empty(fifo_empty), .running(running), .cfg_width(cfg_width),
        .cfg_height(cfg_height), .irq(irq)
    );

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        nchk++;
        if (act !== exp) begin
            nfail++;
            $display("FAIL %s: actual 0x%0h expected 0x%0h", tag, act, exp);
        end
    endtask

    task automatic tick();
        @(negedge clk);
    endtask

    task automatic wr(input logic [1:0] a, input logic [31:0] d);
        @(negedge clk);
        wr_en = 1'b1; wr_addr = a; wr_data = d;
        @(negedge clk);
        wr_en = 1'b0;
    endtask

    task automatic rd(input logic [1:0] a, output logic [31:0] v);
        rd_addr = a;
        #1;
        v = rd_data;
    endtask

    task automatic pulse(input int which);
        @(negedge clk);
        case (which)
            0: vstart = 1'b1;
            1: line_end = 1'b1;
            2: fifo_push = 1'b1;
            default: pix_req = 1'b1;
        endcase
        @(negedge clk);
        vstart = 1'b0; line_end = 1'b0; fifo_push = 1'b0; pix_req = 1'b0;
    endtask

    function automatic logic [31:0] cword(int h, int w, int o, int en);
        return (32'(h) << 16) | (32'(w) << 4) | (32'(o) << 2) | 32'(en);
    endfunction

    task automatic chk_mode(input string tag, input int exp);
        logic [31:0] s;
        rd(2'd1, s);
        chk(tag, {30'd0, s[1:0]}, 32'(exp));
    endtask

    task automatic summary();
        $display("End of test - %0d assertions evaluated, %0d failures", nchk, nfail);
    endtask

    initial begin
        #(200000 * 20);
        if (!finished) begin
            nchk++; nfail++;
            $display("FAIL watchdog: actual timeout expected completion");
            summary();
            $finish;
        end
    end

    initial begin
        logic [31:0] v;
        repeat (3) @(negedge clk);
        rst = 1'b0;
        tick();

        // Reset state (R6, R7, R10)
        rd(2'd1, v); chk("R6 reset status", v, 32'h8);
        rd(2'd0, v); chk("R4 reset ctrl", v, 32'h0);
        chk("R7 reset full", {31'd0, fifo_full}, 0);
        chk("R7 reset empty", {31'd0, fifo_empty}, 1);
        chk("R10 reset irq", {31'd0, irq}, 0);

        // R4 field readback
        begin
            int ws[4] = '{0, 1, 2048, 4095};
            int hs[4] = '{4095, 7, 1, 0};
            for (int i = 0; i < 4; i++) begin
                wr(2'd0, cword(hs[i], ws[i], 1, 0));
                rd(2'd0, v); chk("R4 ctrl readback", v, cword(hs[i], ws[i], 1, 0));
                chk("R4 cfg_width", {20'd0, cfg_width}, 32'(ws[i]));
                chk("R4 cfg_height", {20'd0, cfg_height}, 32'(hs[i]));
            end
        end
        // R6 reset bit reads 0 and clears enable
        wr(2'd0, cword(3, 5, 0, 1) | 32'h2);
        rd(2'd0, v); chk("R6 reset bit self-clears", v, cword(3, 5, 0, 0));

        // R1 enable waits for vstart
        wr(2'd0, cword(2, 10, 0, 1));
        chk_mode("R1 not immediate", 0);
        tick();
        chk_mode("R1 waiting", 1);
        pulse(1);
        repeat (4) tick();
        chk_mode("R1 still waiting", 1);
        chk("R1 running low", {31'd0, running}, 0);
        pulse(0);
        chk_mode("R1 running after vstart", 2);
        chk("R1 running port", {31'd0, running}, 1);

        // R2 / R3 sweep of heights and one-shot
        for (int o = 0; o < 2; o++) begin
            for (int h = 1; h <= 4; h++) begin
                wr(2'd0, 32'h2);
                wr(2'd1, 32'h30);
                wr(2'd0, cword(h, 16, o, 1));
                tick();
                chk_mode("R1 wait", 1);
                pulse(0);
                for (int l = 1; l <= h; l++) begin
                    pulse(1);
                    rd(2'd1, v);
                    if (l < h) begin
                        chk("R2 mid-frame mode", {30'd0, v[1:0]}, 2);
                        chk("R2 no eof yet", {31'd0, v[5]}, 0);
                    end else begin
                        chk(o ? "R3 done mode" : "R2 back to wait", {30'd0, v[1:0]}, o ? 3 : 1);
                        chk("R2 eof set", {31'd0, v[5]}, 1);
                    end
                end
                pulse(0);
                chk_mode(o ? "R3 ignores vstart" : "R2 repeats", o ? 3 : 2);
            end
        end
        // R3 done leaves on disable
        wr(2'd0, cword(1, 16, 1, 0));
        tick();
        chk_mode("R5 done to off", 0);

        // R5 disable mid-frame
        wr(2'd0, cword(4, 16, 0, 1));
        tick();
        pulse(0);
        wr(2'd0, cword(4, 16, 0, 0));
        repeat (3) tick();
        chk_mode("R5 holds until line end", 2);
        pulse(1);
        chk_mode("R5 off at line end", 0);
        wr(2'd0, cword(4, 16, 0, 1));
        tick();
        wr(2'd0, cword(4, 16, 0, 0));
        tick();
        chk_mode("R5 wait to off", 0);

        // R7 FIFO level sweep, R8 no underrun when not running
        wr(2'd1, 32'h30);
        for (int n = 1; n <= DEPTH + 2; n++) begin
            int lvl;
            pulse(2);
            lvl = (n < DEPTH) ? n : DEPTH;
            chk("R7 full on push", {31'd0, fifo_full}, (lvl == DEPTH) ? 1 : 0);
            chk("R7 empty on push", {31'd0, fifo_empty}, 0);
        end
        for (int n = 1; n <= DEPTH + 2; n++) begin
            int lvl;
            pulse(3);
            lvl = (DEPTH - n > 0) ? DEPTH - n : 0;
            chk("R7 full on pop", {31'd0, fifo_full}, 0);
            chk("R7 empty on pop", {31'd0, fifo_empty}, (lvl == 0) ? 1 : 0);
        end
        rd(2'd1, v); chk("R8 no underrun when off", {31'd0, v[4]}, 0);

        // R8 underrun in running mode, R10 gating, R9 W1C
        wr(2'd0, cword(4, 16, 0, 1));
        tick();
        pulse(0);
        pulse(3);
        rd(2'd1, v); chk("R8 underrun set", {31'd0, v[4]}, 1);
        chk("R10 irq gated off", {31'd0, irq}, 0);
        wr(2'd2, 32'h1);
        chk("R10 irq on underrun", {31'd0, irq}, 1);
        rd(2'd2, v); chk("R10 enable readback", v, 32'h1);
        wr(2'd1, 32'h0);
        rd(2'd1, v); chk("R9 write 0 keeps flag", {31'd0, v[4]}, 1);
        wr(2'd1, 32'h10);
        rd(2'd1, v); chk("R9 write 1 clears", {31'd0, v[4]}, 0);
        chk("R10 irq drops", {31'd0, irq}, 0);
        pulse(2);
        pulse(3);
        rd(2'd1, v); chk("R8 no underrun when not empty", {31'd0, v[4]}, 0);
        wr(2'd2, 32'h2);
        repeat (4) pulse(1);
        rd(2'd1, v); chk("R2 eof after frame", {31'd0, v[5]}, 1);
        chk("R10 irq on eof", {31'd0, irq}, 1);
        wr(2'd1, 32'h20);
        chk("R9 eof cleared irq", {31'd0, irq}, 0);

        // R6 flush while running with data
        pulse(0);
        repeat (3) pulse(2);
        chk("R6 fifo not empty", {31'd0, fifo_empty}, 0);
        wr(2'd0, cword(4, 16, 0, 1) | 32'h2);
        chk_mode("R6 mode off", 0);
        chk("R6 fifo empty", {31'd0, fifo_empty}, 1);
        chk("R6 fifo not full", {31'd0, fifo_full}, 0);
        rd(2'd0, v); chk("R6 enable cleared", {31'd0, v[0]}, 0);

        finished = 1;
        summary();
        $finish;
    end

endmodule